// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This controller sits on the platform side of a processor. It walks the processor down and back up a fixed ladder of low-power states: running, Stop-Grant, Sleep and Deep Sleep. It does this by driving three active-low control lines, one each for stop-clock, sleep and deep-sleep. A requester asks for a target state with a one-cycle strobe. The sequencer accepts only a move to an adjacent rung of the ladder. It refuses any other move and flags it as an error.

Four more jobs are timed by the sequencer:
- It drops the base-clock enable a short, bounded time after deep-sleep asserts. A build-time option can keep the clock running instead.
- It restores the clock enable soon after deep-sleep is released.
- After that release, it waits a fixed 15 microseconds for the PLL to settle. Only then does it report Sleep again.
- It raises a hold output that blocks snoop and interrupt traffic while the processor cannot accept it.

A platform reset seen in any state sends the sequencer straight to a reset state. On that path it releases all low-power lines at once and skips the ladder.

Requests that arrive during a timed transition are not lost. The newest one is parked and served as soon as the transition completes.

Top module: `lps_seq_top`

## Requirements
- R1: After block reset all three control lines are high, clock enable is 1, hold is 0, busy is 0 and the status is RUN. Status codes are RUN=0, STOPGRANT=1, SLEEP=2, DEEPSLEEP=3, DS_EXIT_WAIT=4, RESET=5. Request target codes are RUN=0, STOPGRANT=1, SLEEP=2, DEEPSLEEP=3.
- R2: The legal moves are RUN to STOPGRANT and STOPGRANT to RUN. In both, stop-clock changes on the cycle after the request and the status follows in the same cycle.
- R3: The sequencer refuses every other move outside R2, R4, R5, R6 and R7, including a request for the current state. A refused move pulses the error output for one cycle, on the cycle after the request, and changes no control line.
- R4: A STOPGRANT to SLEEP request raises hold on the next cycle. The sleep line falls one cycle after that, and the status becomes SLEEP.
- R5: A SLEEP to STOPGRANT request raises the sleep line on the next cycle. Hold drops one cycle after that, and the status becomes STOPGRANT.
- R6: A SLEEP to DEEPSLEEP request drops the deep-sleep line on the next cycle. Clock enable falls CLKSTOP_DLY cycles (1 or 2) after that, and the status is DEEPSLEEP. With KEEP_CLK=1, clock enable stays 1.
- R7: A DEEPSLEEP to SLEEP request raises the deep-sleep line on the next cycle and reports DS_EXIT_WAIT. Clock enable returns to 1 RESTART_DLY cycles later, which is at most 10. The status becomes SLEEP 15*CLK_MHZ cycles after the line rose.
- R8: Hold is 1 whenever the sleep or deep-sleep line is low, and during the Sleep entry and exit steps.
- R9: At most one of the five outputs (the three control lines, clock enable and hold) changes in any cycle, except on entry to RESET.
- R10: A request arriving while busy is held, and the newest one wins. It is served on the first cycle after busy falls.
- R11: If the platform reset input is high, the next cycle shows RESET. In that cycle all three control lines are high, clock enable is 1 and hold is 1. When the input drops, the next cycle shows RUN with hold 0.
- R12: Busy is 1 exactly during the Sleep entry and exit steps, the clock-stop countdown and DS_EXIT_WAIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high block reset |
| plat_reset | input | 1 | Platform reset line toward the processor |
| req_valid | input | 1 | One-cycle request strobe |
| req_tgt | input | 3 | Requested target state code |
| stpclk_n | output | 1 | Active-low stop-clock control |
| slp_n | output | 1 | Active-low sleep control |
| dpslp_n | output | 1 | Active-low deep-sleep control |
| bclk_en | output | 1 | Base-clock enable |
| hold_req | output | 1 | Blocks snoop and interrupt traffic |
| state_o | output | 3 | Current state code |
| busy_o | output | 1 | Timed transition in progress |
| req_err | output | 1 | Refused-request pulse |

## Verification
The assertions check the following on every cycle:
- The sleep line falls only out of STOPGRANT and with hold already up.
- The deep-sleep line falls only out of SLEEP.
- Clock enable falls only under deep-sleep, within two cycles unless the keep-clock option is set, and returns within ten cycles of release.
- At most one output changes per cycle.
- Hold covers every low-power line.

Only the bench scenarios can show the rest:
- The exact cycle counts of each ladder step and of the 15-microsecond settle.
- The refusal of illegal moves.
- That a parked request is served right after a wait ends.
- The reset bypass taken from deep sleep.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [2:0] {
    S_RUN   = 3'd0,
    S_SG    = 3'd1,
    S_SLEEP = 3'd2,
    S_DEEP  = 3'd3,
    S_DSX   = 3'd4,
    S_RST   = 3'd5
  } lps_state_e;

  // internal phases: stable rungs plus the timed steps between them
  typedef enum logic [3:0] {
    P_RUN    = 4'd0,
    P_SG     = 4'd1,
    P_SLPRE  = 4'd2,
    P_SLEEP  = 4'd3,
    P_SLEXIT = 4'd4,
    P_DPIN   = 4'd5,
    P_DEEP   = 4'd6,
    P_DSX    = 4'd7,
    P_RST    = 4'd8
  } lps_phase_e;

  function automatic lps_state_e phase_report(lps_phase_e p);
    case (p)
      P_RUN:    return S_RUN;
      P_SG:     return S_SG;
      P_SLPRE:  return S_SG;
      P_SLEEP:  return S_SLEEP;
      P_SLEXIT: return S_SLEEP;
      P_DPIN:   return S_DEEP;
      P_DEEP:   return S_DEEP;
      P_DSX:    return S_DSX;
      default:  return S_RST;
    endcase
  endfunction

  function automatic logic phase_timed(lps_phase_e p);
    return (p == P_SLPRE) || (p == P_SLEXIT) || (p == P_DPIN) || (p == P_DSX);
  endfunction

endpackage

// File: rtl/lps_timer.sv
module lps_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lps_req_hold.sv
module lps_req_hold #(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          capture,
  input  logic [TW-1:0] cap_tgt,
  input  logic          take,
  output logic          pend_v,
  output logic [TW-1:0] pend_tgt
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pend_v   <= 1'b0;
      pend_tgt <= '0;
    end else if (capture) begin
      pend_v   <= 1'b1;
      pend_tgt <= cap_tgt;
    end else if (take) begin
      pend_v   <= 1'b0;
    end
  end
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
  import lps_pkg::*;
#(
  parameter int CW          = 11,
  parameter int CLKSTOP_DLY = 2,
  parameter int RESTART_DLY = 2,
  parameter int SETTLE      = 1500
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          plat_reset,
  input  logic          srv_v,
  input  logic [2:0]    srv_tgt,
  input  logic [CW-1:0] cnt,
  input  logic          clk_off_val,
  output lps_phase_e    phase,
  output logic          tmr_run,
  output logic          stpclk_n,
  output logic          slp_n,
  output logic          dpslp_n,
  output logic          bclk_en,
  output logic          hold_req,
  output logic          req_err
);
  localparam logic [CW-1:0] STOP_LAST    = CW'(CLKSTOP_DLY - 1);
  localparam logic [CW-1:0] RESTART_LAST = CW'(RESTART_DLY - 1);
  localparam logic [CW-1:0] SETTLE_LAST  = CW'(SETTLE - 1);

  assign tmr_run = (phase == P_DPIN) || (phase == P_DSX);

  always_ff @(posedge clk) begin
    req_err <= 1'b0;
    if (rst) begin
      phase    <= P_RUN;
      stpclk_n <= 1'b1;
      slp_n    <= 1'b1;
      dpslp_n  <= 1'b1;
      bclk_en  <= 1'b1;
      hold_req <= 1'b0;
    end else if (plat_reset && phase != P_RST) begin
      // reset bypass: release every low-power line together
      phase    <= P_RST;
      stpclk_n <= 1'b1;
      slp_n    <= 1'b1;
      dpslp_n  <= 1'b1;
      bclk_en  <= 1'b1;
      hold_req <= 1'b1;
    end else begin
      case (phase)
        P_RST: begin
          if (!plat_reset) begin
            phase    <= P_RUN;
            hold_req <= 1'b0;
          end else if (srv_v) begin
            req_err <= 1'b1;
          end
        end
        P_SLPRE: begin
          slp_n <= 1'b0;
          phase <= P_SLEEP;
        end
        P_SLEXIT: begin
          hold_req <= 1'b0;
          phase    <= P_SG;
        end
        P_DPIN: begin
          if (cnt == STOP_LAST) begin
            bclk_en <= clk_off_val;
            phase   <= P_DEEP;
          end
        end
        P_DSX: begin
          if (cnt == RESTART_LAST) bclk_en <= 1'b1;
          if (cnt == SETTLE_LAST)  phase   <= P_SLEEP;
        end
        default: begin
          if (srv_v) begin
            if (phase == P_RUN && srv_tgt == 3'(S_SG)) begin
              stpclk_n <= 1'b0;
              phase    <= P_SG;
            end else if (phase == P_SG && srv_tgt == 3'(S_RUN)) begin
              stpclk_n <= 1'b1;
              phase    <= P_RUN;
            end else if (phase == P_SG && srv_tgt == 3'(S_SLEEP)) begin
              hold_req <= 1'b1;
              phase    <= P_SLPRE;
            end else if (phase == P_SLEEP && srv_tgt == 3'(S_SG)) begin
              slp_n <= 1'b1;
              phase <= P_SLEXIT;
            end else if (phase == P_SLEEP && srv_tgt == 3'(S_DEEP)) begin
              dpslp_n <= 1'b0;
              phase   <= P_DPIN;
            end else if (phase == P_DEEP && srv_tgt == 3'(S_SLEEP)) begin
              dpslp_n <= 1'b1;
              phase   <= P_DSX;
            end else begin
              req_err <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lps_seq_top.sv
module lps_seq_top
  import lps_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int SETTLE_US   = 15,
  parameter int CLKSTOP_DLY = 2,
  parameter int RESTART_DLY = 2,
  parameter bit KEEP_CLK    = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       plat_reset,
  input  logic       req_valid,
  input  logic [2:0] req_tgt,
  output logic       stpclk_n,
  output logic       slp_n,
  output logic       dpslp_n,
  output logic       bclk_en,
  output logic       hold_req,
  output logic [2:0] state_o,
  output logic       busy_o,
  output logic       req_err
);
  localparam int SETTLE = SETTLE_US * CLK_MHZ;
  localparam int CW     = $clog2(SETTLE + 1);

  lps_phase_e    phase;
  logic          tmr_run;
  logic [CW-1:0] cnt;
  logic          pend_v;
  logic [2:0]    pend_tgt;
  logic          srv_v;
  logic [2:0]    srv_tgt;
  logic          busy;
  logic          clk_off_val;

  generate
    if (KEEP_CLK) begin : g_keep
      assign clk_off_val = 1'b1;
    end else begin : g_gate
      assign clk_off_val = 1'b0;
    end
  endgenerate

  assign busy    = phase_timed(phase);
  assign srv_v   = !busy && (req_valid || pend_v);
  assign srv_tgt = req_valid ? req_tgt : pend_tgt;

  lps_timer #(.CW(CW)) timer_i (
    .clk (clk),
    .rst (rst),
    .run (tmr_run),
    .cnt (cnt)
  );

  lps_req_hold #(.TW(3)) hold_i (
    .clk      (clk),
    .rst      (rst),
    .flush    (plat_reset),
    .capture  (busy && req_valid),
    .cap_tgt  (req_tgt),
    .take     (!busy),
    .pend_v   (pend_v),
    .pend_tgt (pend_tgt)
  );

  lps_fsm #(
    .CW          (CW),
    .CLKSTOP_DLY (CLKSTOP_DLY),
    .RESTART_DLY (RESTART_DLY),
    .SETTLE      (SETTLE)
  ) fsm_i (
    .clk         (clk),
    .rst         (rst),
    .plat_reset  (plat_reset),
    .srv_v       (srv_v),
    .srv_tgt     (srv_tgt),
    .cnt         (cnt),
    .clk_off_val (clk_off_val),
    .phase       (phase),
    .tmr_run     (tmr_run),
    .stpclk_n    (stpclk_n),
    .slp_n       (slp_n),
    .dpslp_n     (dpslp_n),
    .bclk_en     (bclk_en),
    .hold_req    (hold_req),
    .req_err     (req_err)
  );

  assign state_o = 3'(phase_report(phase));
  assign busy_o  = busy;
endmodule

// File: rtl/lps_seq_chk.sv
module lps_seq_chk
  import lps_pkg::*;
#(
  parameter bit KEEP_CLK = 1'b0
) (
  input logic       clk,
  input logic       rst,
  input logic       stpclk_n,
  input logic       slp_n,
  input logic       dpslp_n,
  input logic       bclk_en,
  input logic       hold_req,
  input logic [2:0] state_o,
  input logic       busy_o
);
  logic [3:0] drop_cnt;
  logic [3:0] wake_cnt;

  always_ff @(posedge clk) begin
    if (rst || dpslp_n || !bclk_en) drop_cnt <= '0;
    else if (drop_cnt != 4'hF)      drop_cnt <= drop_cnt + 1'b1;
    if (rst || !dpslp_n || bclk_en) wake_cnt <= '0;
    else if (wake_cnt != 4'hF)      wake_cnt <= wake_cnt + 1'b1;
  end

  assert_sleep_from_sg_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(slp_n) |-> ($past(state_o) == 3'(S_SG)) && $past(hold_req));

  assert_deep_from_sleep_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(dpslp_n) |-> ($past(state_o) == 3'(S_SLEEP)) && !slp_n);

  assert_deep_exit_wait_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(dpslp_n) |-> (state_o == 3'(S_DSX)) || (state_o == 3'(S_RST)));

  assert_clk_drop_gated_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(bclk_en) |-> !dpslp_n);

  assert_clk_drop_window_R6: assert property (@(posedge clk) disable iff (rst)
    KEEP_CLK || (drop_cnt <= 4'd2));

  assert_clk_restart_window_R7: assert property (@(posedge clk) disable iff (rst)
    wake_cnt < 4'd10);

  assert_hold_cover_R8: assert property (@(posedge clk) disable iff (rst)
    (!slp_n || !dpslp_n) |-> hold_req);

  assert_one_change_R9: assert property (@(posedge clk) disable iff (rst)
    (state_o != 3'(S_RST)) |->
      $countones({stpclk_n ^ $past(stpclk_n), slp_n ^ $past(slp_n),
                  dpslp_n ^ $past(dpslp_n), bclk_en ^ $past(bclk_en),
                  hold_req ^ $past(hold_req)}) <= 1);

  assert_reset_release_R11: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'(S_RST)) |-> slp_n && stpclk_n && dpslp_n && bclk_en);

  assert_busy_wait_R12: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'(S_DSX)) |-> busy_o);
endmodule

bind lps_seq_top lps_seq_chk #(.KEEP_CLK(KEEP_CLK)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .stpclk_n (stpclk_n),
  .slp_n    (slp_n),
  .dpslp_n  (dpslp_n),
  .bclk_en  (bclk_en),
  .hold_req (hold_req),
  .state_o  (state_o),
  .busy_o   (busy_o)
);

// File: tb/lps_seq_top_tb_top.sv
module lps_seq_top_tb_top;
  localparam int SETTLE = 15 * 100;
  localparam int RUN_C = 0, SG_C = 1, SL_C = 2, DP_C = 3, DSX_C = 4, RST_C = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic plat_reset = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_tgt = 3'd0;
  logic stpclk_n, slp_n, dpslp_n, bclk_en, hold_req, busy_o, req_err;
  logic [2:0] state_o;
  logic k_stpclk_n, k_slp_n, k_dpslp_n, k_bclk_en, k_hold, k_busy, k_err;
  logic [2:0] k_state;

  int errors = 0;
  int nchk = 0;

  always #5 clk = ~clk;

  lps_seq_top dut_i (
    .clk(clk), .rst(rst), .plat_reset(plat_reset), .req_valid(req_valid),
    .req_tgt(req_tgt), .stpclk_n(stpclk_n), .slp_n(slp_n), .dpslp_n(dpslp_n),
    .bclk_en(bclk_en), .hold_req(hold_req), .state_o(state_o), .busy_o(busy_o),
    .req_err(req_err));

  lps_seq_top #(.KEEP_CLK(1'b1)) dut_k (
    .clk(clk), .rst(rst), .plat_reset(plat_reset), .req_valid(req_valid),
    .req_tgt(req_tgt), .stpclk_n(k_stpclk_n), .slp_n(k_slp_n), .dpslp_n(k_dpslp_n),
    .bclk_en(k_bclk_en), .hold_req(k_hold), .state_o(k_state), .busy_o(k_busy),
    .req_err(k_err));

  function automatic bit exp_legal(int cur, int tgt);
    return (cur == RUN_C && tgt == SG_C) || (cur == SG_C && tgt == RUN_C) ||
           (cur == SG_C && tgt == SL_C) || (cur == SL_C && tgt == SG_C) ||
           (cur == SL_C && tgt == DP_C) || (cur == DP_C && tgt == SL_C);
  endfunction

  function automatic int exp_next(int cur, int tgt);
    return exp_legal(cur, tgt) ? tgt : cur;
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(int tgt);
    @(negedge clk);
    req_valid = 1'b1;
    req_tgt   = 3'(tgt);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, nchk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    nchk++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    int cur;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 stpclk_n", stpclk_n, 1);
    chk("R1 slp_n", slp_n, 1);
    chk("R1 dpslp_n", dpslp_n, 1);
    chk("R1 bclk_en", bclk_en, 1);
    chk("R1 hold", hold_req, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 state", state_o, RUN_C);

    // R3 sleep from RUN refused
    issue(SL_C);
    chk("R3 err", req_err, 1);
    chk("R3 slp_n", slp_n, 1);
    chk("R3 state", state_o, RUN_C);
    @(negedge clk);
    chk("R3 err pulse", req_err, 0);

    // R2 RUN -> SG
    issue(SG_C);
    chk("R2 stpclk_n", stpclk_n, 0);
    chk("R2 state", state_o, SG_C);
    chk("R12 busy", busy_o, 0);

    // R4 SG -> SLEEP
    issue(SL_C);
    chk("R4 hold", hold_req, 1);
    chk("R9 slp_n unchanged", slp_n, 1);
    chk("R12 busy", busy_o, 1);
    @(negedge clk);
    chk("R4 slp_n", slp_n, 0);
    chk("R4 state", state_o, SL_C);
    chk("R8 hold", hold_req, 1);

    // R6 SLEEP -> DEEP
    issue(DP_C);
    chk("R6 dpslp_n", dpslp_n, 0);
    chk("R6 bclk early", bclk_en, 1);
    @(negedge clk);
    chk("R6 bclk early2", bclk_en, 1);
    @(negedge clk);
    chk("R6 bclk off", bclk_en, 0);
    chk("R6 state", state_o, DP_C);
    chk("R6 keep clk", k_bclk_en, 1);

    // R3 DEEP -> SG refused
    issue(SG_C);
    chk("R3 err deep", req_err, 1);
    chk("R3 dpslp_n held", dpslp_n, 0);

    // R7 DEEP -> SLEEP with parked request (R10)
    issue(SL_C);
    chk("R7 dpslp_n", dpslp_n, 1);
    chk("R7 state", state_o, DSX_C);
    chk("R12 busy dsx", busy_o, 1);
    @(negedge clk);
    chk("R7 bclk still off", bclk_en, 0);
    @(negedge clk);
    chk("R7 bclk restored", bclk_en, 1);
    issue(SG_C);
    chk("R10 no err", req_err, 0);
    repeat (SETTLE - 1 - 4) @(negedge clk);
    chk("R7 still waiting", state_o, DSX_C);
    chk("R10 parked", slp_n, 0);
    @(negedge clk);
    chk("R7 back in sleep", state_o, SL_C);
    chk("R12 busy done", busy_o, 0);
    @(negedge clk);
    chk("R10 served", slp_n, 1);
    chk("R5 hold kept", hold_req, 1);
    @(negedge clk);
    chk("R5 hold drop", hold_req, 0);
    chk("R5 state", state_o, SG_C);

    // R2 SG -> RUN
    issue(RUN_C);
    chk("R2 stpclk_n up", stpclk_n, 1);
    chk("R2 state run", state_o, RUN_C);

    // R11 reset while in deep sleep
    issue(SG_C);
    issue(SL_C);
    @(negedge clk);
    issue(DP_C);
    repeat (2) @(negedge clk);
    chk("R11 pre deep", state_o, DP_C);
    plat_reset = 1'b1;
    @(negedge clk);
    chk("R11 state", state_o, RST_C);
    chk("R11 slp_n", slp_n, 1);
    chk("R11 stpclk_n", stpclk_n, 1);
    chk("R11 dpslp_n", dpslp_n, 1);
    chk("R11 bclk", bclk_en, 1);
    chk("R11 hold", hold_req, 1);
    plat_reset = 1'b0;
    @(negedge clk);
    chk("R11 run", state_o, RUN_C);
    chk("R11 hold off", hold_req, 0);

    // random walk over the ladder
    cur = RUN_C;
    for (int i = 0; i < 40; i++) begin
      int tgt;
      tgt = int'($urandom % 4);
      issue(tgt);
      chk("R3 random err", req_err, exp_legal(cur, tgt) ? 0 : 1);
      settle();
      cur = exp_next(cur, tgt);
      chk("R2 random state", state_o, cur);
      chk("R8 random hold", hold_req, (cur == SL_C || cur == DP_C) ? 1 : 0);
      chk("R6 random keep", k_bclk_en, 1);
    end

    report();
    $finish;
  end
endmodule